// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one channel of a general-purpose timer used as a compare output. It reads the counter value, the count direction and an update pulse that the timer core shares with all channels. From these, a compare value and a three-bit behaviour code, it keeps a registered, active-high reference level. From that level it drives a main pin and a complementary pin. Each pin has its own polarity bit.

Configuration arrives on plain write strobes, with no back-pressure; the block is never busy. A configuration write loads the behaviour code, the clear enable, the shadow enable, both polarity bits, the enable bit and the two-bit direction code in one cycle. A compare write goes to a preload register or straight to the active register, depending on the shadow enable. The reference is updated on every clock edge from the values present before that edge. A configuration or compare write therefore affects the reference one edge after it is accepted. The pins follow the reference and the configuration combinationally.

Top module: `oc_channel`

## Requirements
- R1: Behaviour code 3'b100 drives the reference low on the next edge and 3'b101 drives it high; 3'b000 frozen, 3'b001 set, 3'b010 clear, 3'b011 toggle, 3'b110 PWM-A and 3'b111 PWM-B complete the encoding.
- R2: In frozen mode (3'b000) the reference keeps its level whatever the counter and compare values.
- R3: Set, clear and toggle modes act only on an edge where the counter equals the active compare value: they drive the reference to 1, to 0, or to its inverse. On any other edge the reference holds.
- R4: PWM-A level is 1 when counting up with counter < compare, and 0 otherwise. Counting down, it is 0 when counter > compare and 1 otherwise.
- R5: PWM-B level is the inverse of the PWM-A level in both directions.
- R6: In a PWM mode the reference takes the PWM level only when one of these holds: the previous edge's mode was frozen, the previous edge's mode was the other PWM mode, or the raw compare result (the PWM-A level) differs from the one at the previous edge. Otherwise the reference holds.
- R7: When the clear enable is 1 and the external trigger input is high, the next reference is 0, overriding every mode.
- R8: The main pin equals the reference XOR its polarity bit. The complementary pin equals the inverted reference XOR its own polarity bit.
- R9: The channel is active only when the enable bit is 1 and the direction code is 2'b00 (output). While it is not active, each pin sits at its inactive level, which equals its polarity bit.
- R10: The direction code changes on a configuration write only if the enable bit was 0 before that write; other fields always load.
- R11: With shadow enable set, compare writes land in the preload register, and the update pulse copies the preload into the active register. The copy uses the preload value from before any same-cycle write. With shadow enable clear, writes also load the active register at once.
- R12: After reset the reference, behaviour code, enable bit, direction, polarities and both compare registers are 0, so both pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Shared counter value |
| cnt_down_i | input | 1 | 1 while the counter counts down |
| upd_i | input | 1 | Update-event pulse from the timer core |
| ext_trig_i | input | 1 | External clear trigger, level sensitive |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 3 | Behaviour code |
| cfg_clr_en_i | input | 1 | Clear-on-trigger enable |
| cfg_shadow_i | input | 1 | Compare shadow enable |
| cfg_pol_main_i | input | 1 | Main pin polarity (1 = active low) |
| cfg_pol_comp_i | input | 1 | Complementary pin polarity (1 = active low) |
| cfg_en_i | input | 1 | Channel enable |
| cfg_dir_i | input | 2 | Direction code, 2'b00 = output |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | CNT_W | Compare write value |
| ref_o | output | 1 | Active-high reference level |
| out_main_o | output | 1 | Main output pin |
| out_comp_o | output | 1 | Complementary output pin |
| dir_o | output | 2 | Current direction code |

## Verification
The bench builds the block with the default CNT_W of 16. Most counter and compare values are drawn from a small range, the equal and off-by-one neighbours and the ends 0 and 16'hFFFF. Exact matches and both strict-less and less-or-equal boundaries therefore come up often, in both count directions. Configuration writes that change the mode, shadowing and direction while the channel is enabled land on random edges. This reaches the PWM entry rules, the preload timing and the direction lock.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OCM_FROZEN = 3'b000,
    OCM_SET    = 3'b001,
    OCM_CLR    = 3'b010,
    OCM_TOG    = 3'b011,
    OCM_LO     = 3'b100,
    OCM_HI     = 3'b101,
    OCM_PWMA   = 3'b110,
    OCM_PWMB   = 3'b111
  } ocm_e;

  typedef struct packed {
    ocm_e       mode;
    logic       clr_en;
    logic       shadow_en;
    logic       pol_main;
    logic       pol_comp;
    logic       en;
    logic [1:0] dir;
  } oc_cfg_t;

  localparam logic [1:0] DIR_OUT = 2'b00;
endpackage

// File: rtl/oc_cmp_shadow.sv
module oc_cmp_shadow #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shadow_en,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             upd,
  output logic [CNT_W-1:0] active
);
  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] act_q;

  // R11: preload and active compare registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (we) pre_q <= wdata;
      if (shadow_en) begin
        if (upd) act_q <= pre_q;
      end else if (we) begin
        act_q <= wdata;
      end
    end
  end

  assign active = act_q;

  assert_shadow_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_en && !upd) |=> $stable(act_q));
  assert_direct_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!shadow_en && we) |=> (act_q == $past(wdata)));
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ocm_e             mode,
  input  logic             clr_en,
  input  logic             ext_trig,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_down,
  input  logic [CNT_W-1:0] cmp,
  output logic             ref_q
);
  logic match;
  logic res;
  logic pwm_lvl;
  logic clr_hit;
  logic is_pwm;
  logic prev_pwm;
  logic pwm_refresh;
  logic prev_res;
  ocm_e prev_mode;
  logic nxt;

  assign match    = (cnt == cmp);
  // raw compare result = PWM-A level (R4)
  assign res      = cnt_down ? (cnt <= cmp) : (cnt < cmp);
  assign pwm_lvl  = (mode == OCM_PWMB) ? ~res : res;   // R5
  assign clr_hit  = clr_en && ext_trig;                // R7
  assign is_pwm   = (mode == OCM_PWMA) || (mode == OCM_PWMB);
  assign prev_pwm = (prev_mode == OCM_PWMA) || (prev_mode == OCM_PWMB);
  // R6: entry from frozen, swap between PWM modes, or result change
  assign pwm_refresh = (prev_mode == OCM_FROZEN) ||
                       (prev_pwm && (prev_mode != mode)) ||
                       (res != prev_res);

  always_comb begin
    nxt = ref_q;
    if (clr_hit) begin
      nxt = 1'b0;
    end else begin
      unique case (mode)
        OCM_FROZEN: nxt = ref_q;
        OCM_SET:    if (match) nxt = 1'b1;
        OCM_CLR:    if (match) nxt = 1'b0;
        OCM_TOG:    if (match) nxt = ~ref_q;
        OCM_LO:     nxt = 1'b0;
        OCM_HI:     nxt = 1'b1;
        OCM_PWMA,
        OCM_PWMB:   if (pwm_refresh) nxt = pwm_lvl;
        default:    nxt = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q     <= 1'b0;
      prev_res  <= 1'b0;
      prev_mode <= OCM_FROZEN;
    end else begin
      ref_q     <= nxt;
      prev_res  <= res;
      prev_mode <= mode;
    end
  end

  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !ref_q);
  assert_force_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_hit && mode == OCM_HI) |=> ref_q);
  assert_frozen_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_hit && mode == OCM_FROZEN) |=> $stable(ref_q));
  assert_no_match_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_hit && !match && (mode == OCM_SET || mode == OCM_CLR || mode == OCM_TOG))
      |=> $stable(ref_q));
  assert_pwm_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_hit && is_pwm && prev_mode == mode && res == prev_res) |=> $stable(ref_q));
endmodule

// File: rtl/oc_out_drv.sv
module oc_out_drv #(
  parameter int N_PINS = 2
) (
  input  logic              active,
  input  logic              ref_lvl,
  input  logic [N_PINS-1:0] pol,
  input  logic [N_PINS-1:0] inv,
  output logic [N_PINS-1:0] pin
);
  // R8, R9: per-pin polarity, inactive level equals polarity bit
  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign pin[i] = active ? (ref_lvl ^ inv[i] ^ pol[i]) : pol[i];
  end
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_down_i,
  input  logic             upd_i,
  input  logic             ext_trig_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_mode_i,
  input  logic             cfg_clr_en_i,
  input  logic             cfg_shadow_i,
  input  logic             cfg_pol_main_i,
  input  logic             cfg_pol_comp_i,
  input  logic             cfg_en_i,
  input  logic [1:0]       cfg_dir_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic             ref_o,
  output logic             out_main_o,
  output logic             out_comp_o,
  output logic [1:0]       dir_o
);
  localparam int N_PINS = 2;

  oc_cfg_t          cfg_q;
  logic [CNT_W-1:0] cmp_act;
  logic             ref_lvl;
  logic             chan_active;
  logic [N_PINS-1:0] pins;

  // R10, R12: configuration register, direction locked while enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q.mode      <= ocm_e'(cfg_mode_i);
      cfg_q.clr_en    <= cfg_clr_en_i;
      cfg_q.shadow_en <= cfg_shadow_i;
      cfg_q.pol_main  <= cfg_pol_main_i;
      cfg_q.pol_comp  <= cfg_pol_comp_i;
      cfg_q.en        <= cfg_en_i;
      if (!cfg_q.en) cfg_q.dir <= cfg_dir_i;
    end
  end

  oc_cmp_shadow #(.CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .shadow_en (cfg_q.shadow_en),
    .we        (cmp_we_i),
    .wdata     (cmp_wdata_i),
    .upd       (upd_i),
    .active    (cmp_act)
  );

  oc_ref_gen #(.CNT_W(CNT_W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (cfg_q.mode),
    .clr_en   (cfg_q.clr_en),
    .ext_trig (ext_trig_i),
    .cnt      (cnt_i),
    .cnt_down (cnt_down_i),
    .cmp      (cmp_act),
    .ref_q    (ref_lvl)
  );

  assign chan_active = cfg_q.en && (cfg_q.dir == DIR_OUT);

  oc_out_drv #(.N_PINS(N_PINS)) u_out (
    .active  (chan_active),
    .ref_lvl (ref_lvl),
    .pol     ({cfg_q.pol_comp, cfg_q.pol_main}),
    .inv     (2'b10),
    .pin     (pins)
  );

  assign ref_o      = ref_lvl;
  assign out_main_o = pins[0];
  assign out_comp_o = pins[1];
  assign dir_o      = cfg_q.dir;

  assert_dir_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.en |=> $stable(cfg_q.dir));
  assert_idle_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_active |-> (out_main_o == cfg_q.pol_main && out_comp_o == cfg_q.pol_comp));
  assert_pins_opposite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_active && cfg_q.pol_main == cfg_q.pol_comp) |-> (out_main_o != out_comp_o));
endmodule

// File: tb/tb_oc_channel.sv
module tb_oc_channel;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [CNT_W-1:0] cnt_i;
  logic cnt_down_i, upd_i, ext_trig_i, cfg_we_i;
  logic [2:0] cfg_mode_i;
  logic cfg_clr_en_i, cfg_shadow_i, cfg_pol_main_i, cfg_pol_comp_i, cfg_en_i;
  logic [1:0] cfg_dir_i;
  logic cmp_we_i;
  logic [CNT_W-1:0] cmp_wdata_i;
  logic ref_o, out_main_o, out_comp_o;
  logic [1:0] dir_o;

  always #10 clk = ~clk;

  oc_channel #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cnt_down_i(cnt_down_i),
    .upd_i(upd_i), .ext_trig_i(ext_trig_i), .cfg_we_i(cfg_we_i),
    .cfg_mode_i(cfg_mode_i), .cfg_clr_en_i(cfg_clr_en_i),
    .cfg_shadow_i(cfg_shadow_i), .cfg_pol_main_i(cfg_pol_main_i),
    .cfg_pol_comp_i(cfg_pol_comp_i), .cfg_en_i(cfg_en_i), .cfg_dir_i(cfg_dir_i),
    .cmp_we_i(cmp_we_i), .cmp_wdata_i(cmp_wdata_i), .ref_o(ref_o),
    .out_main_o(out_main_o), .out_comp_o(out_comp_o), .dir_o(dir_o)
  );

  int vectors = 0;
  int errors  = 0;

  // behavioural reference model state
  int m_mode, m_pmode;
  bit m_clr, m_sh, m_pm, m_pc, m_en, m_ref, m_pres, m_lastclr;
  int m_dir, m_pre, m_act;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pmode = 0; m_clr = 0; m_sh = 0; m_pm = 0; m_pc = 0;
      m_en = 0; m_ref = 0; m_pres = 0; m_dir = 0; m_pre = 0; m_act = 0;
      m_lastclr = 0;
    end else begin
      int c, a;
      bit res, lvl, refresh, nref;
      c = int'(cnt_i); a = m_act;
      res = cnt_down_i ? (c <= a) : (c < a);
      lvl = (m_mode == 7) ? !res : res;
      refresh = (m_pmode == 0) || ((m_pmode == 6 || m_pmode == 7) && m_pmode != m_mode)
                || (res != m_pres);
      nref = m_ref;
      m_lastclr = m_clr && ext_trig_i;
      if (m_lastclr) nref = 0;
      else case (m_mode)
        1: if (c == a) nref = 1;
        2: if (c == a) nref = 0;
        3: if (c == a) nref = !m_ref;
        4: nref = 0;
        5: nref = 1;
        6, 7: if (refresh) nref = lvl;
        default: ;
      endcase
      m_ref = nref; m_pres = res; m_pmode = m_mode;
      if (m_sh) begin
        if (upd_i) m_act = m_pre;
      end else if (cmp_we_i) m_act = int'(cmp_wdata_i);
      if (cmp_we_i) m_pre = int'(cmp_wdata_i);
      if (cfg_we_i) begin
        if (!m_en) m_dir = int'(cfg_dir_i);
        m_mode = int'(cfg_mode_i); m_clr = cfg_clr_en_i; m_sh = cfg_shadow_i;
        m_pm = cfg_pol_main_i; m_pc = cfg_pol_comp_i; m_en = cfg_en_i;
      end
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b (mode %0d)", tag, what, act, exp, m_pmode);
    end
  endtask

  task automatic compare_all();
    bit live, e_main, e_comp;
    string tag;
    live = m_en && (m_dir == 0);
    e_main = live ? (m_ref ^ m_pm) : m_pm;
    e_comp = live ? (!m_ref ^ m_pc) : m_pc;
    // tag by the mode that produced the current reference
    if (m_lastclr) tag = "R7";
    else case (m_pmode)
      0: tag = "R2";
      1, 2, 3: tag = "R3";
      4, 5: tag = "R1";
      default: tag = "R4 R5 R6 R11";
    endcase
    chk(ref_o, m_ref, tag, "reference");
    chk(out_main_o, e_main, live ? "R8" : "R9", "main pin");
    chk(out_comp_o, e_comp, live ? "R8" : "R9", "comp pin");
    vectors++;
    if (int'(dir_o) != m_dir) begin
      errors++;
      $display("FAIL R10 direction: actual %0d expected %0d", dir_o, m_dir);
    end
  endtask

  function automatic logic [CNT_W-1:0] pick_val(input int near);
    int r;
    r = int'($urandom_range(0, 9));
    case (r)
      0: return '0;
      1: return '1;
      2: return CNT_W'(near);
      3: return CNT_W'(near + 1);
      4: return CNT_W'(near - 1);
      default: return CNT_W'($urandom_range(0, 12));
    endcase
  endfunction

  task automatic drive_idle();
    cnt_i = '0; cnt_down_i = 0; upd_i = 0; ext_trig_i = 0; cfg_we_i = 0;
    cfg_mode_i = 0; cfg_clr_en_i = 0; cfg_shadow_i = 0; cfg_pol_main_i = 0;
    cfg_pol_comp_i = 0; cfg_en_i = 0; cfg_dir_i = 0; cmp_we_i = 0; cmp_wdata_i = '0;
  endtask

  task automatic drive_rand(input int phase);
    cfg_we_i = ($urandom_range(0, 29) == 0);
    cfg_mode_i = 3'($urandom_range(0, 7));
    cfg_clr_en_i = ($urandom_range(0, 2) == 0);
    cfg_shadow_i = phase[0];
    cfg_pol_main_i = 1'($urandom_range(0, 1));
    cfg_pol_comp_i = 1'($urandom_range(0, 1));
    cfg_en_i = ($urandom_range(0, 5) != 0);
    cfg_dir_i = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
    cmp_we_i = ($urandom_range(0, 11) == 0);
    cmp_wdata_i = pick_val(int'(cnt_i));
    upd_i = ($urandom_range(0, 7) == 0);
    ext_trig_i = ($urandom_range(0, 9) == 0);
    cnt_down_i = (phase[1]) ? 1'($urandom_range(0, 1)) : phase[2];
    cnt_i = pick_val(m_act);
  endtask

  initial begin
    drive_idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R12: reset state at the ports
    chk(ref_o, 0, "R12", "reset reference");
    chk(out_main_o, 0, "R12", "reset main pin");
    chk(out_comp_o, 0, "R12", "reset comp pin");
    vectors++;
    if (dir_o !== 2'b00) begin
      errors++;
      $display("FAIL R12 reset direction: actual %0d expected 0", dir_o);
    end
    rst_n = 1;
    for (int ph = 0; ph < 24; ph++) begin
      for (int c = 0; c < 300; c++) begin
        @(negedge clk);
        compare_all();
        drive_rand(ph);
      end
    end
    @(negedge clk);
    compare_all();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule